// File: doc/BRIEF.md
# Serial Transmit Path with Holding and Empty Status

This block turns bytes written by a host into asynchronous serial frames. A write strobe puts a byte into a holding stage, which is either a single register or, when the buffered mode input is high, a first-in first-out queue of `DEPTH` entries. A shifter takes the oldest byte whenever it finishes a character, or at once when it is idle. It then drives the line with a low start bit, 5 to 8 data bits least significant first, an optional parity bit and one or two high stop bits. Every bit lasts sixteen ticks of an external baud strobe.

Two status flags come back to the host. The first, `hold_empty`, says the holding stage can take more data. The second, `tx_empty`, says that the holding stage and the shifter are both drained, so the line is quiet. An interrupt request follows `hold_empty` when the host has enabled it. The line configuration and the buffered-mode input may change only while `tx_empty` is high.

Top module: `uart_tx_path`

## Requirements
- R1: A frame is one start bit (0), then `cfg_len`+5 data bits (`cfg_len` 0..3 gives 5..8) sent least significant first, then a parity bit when `cfg_par_en` is 1, then one stop bit (1), or two when `cfg_stop2` is 1. The parity bit is the XOR of the data bits sent when `cfg_par_even` is 1, and its inverse when it is 0.
- R2: Each bit stays on `txd` for 16 cycles in which `baud_tick` is high, so a frame of N bits lasts 16·N ticks from the start bit to the rise of `tx_empty`.
- R3: After reset `txd`=1, `hold_empty`=1, `tx_empty`=1 and `irq`=0, and `txd` is 1 whenever nothing is being sent.
- R4: With `fifo_en`=0, a write into an empty holding register clears `hold_empty` on the following cycle. The flag sets again on the cycle in which the byte moves into the shifter, which is the next cycle if the shifter is idle.
- R5: With `fifo_en`=0, the holding stage holds one byte. A write while it is occupied (and not being emptied in that cycle) is discarded.
- R6: With `fifo_en`=1, up to `DEPTH` bytes wait in the queue and are sent in write order. `hold_empty` is 0 while any byte waits and 1 only when the queue is empty.
- R7: With `fifo_en`=1, a write while the queue holds `DEPTH` bytes and none leaves in that cycle is discarded.
- R8: `tx_empty` is 1 only when the holding stage is empty and the shifter is idle. It rises in the cycle that ends the last stop bit of the final byte.
- R9: `irq` equals `hold_empty` AND the value that `hold_irq_en` had one cycle earlier.
- R10: When another byte is waiting, its start bit follows the last stop bit of the current frame with no idle time in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host write strobe for one cycle |
| wr_data | input | 8 | Byte to send |
| fifo_en | input | 1 | 1 selects the queue, 0 selects the single holding register |
| cfg_len | input | 2 | Data length code, bits = code + 5 |
| cfg_par_en | input | 1 | Adds a parity bit |
| cfg_par_even | input | 1 | 1 even parity, 0 odd parity |
| cfg_stop2 | input | 1 | 1 sends two stop bits |
| hold_irq_en | input | 1 | Enables the holding-empty interrupt |
| baud_tick | input | 1 | Oversampling strobe, 16 per bit |
| txd | output | 1 | Serial line, idles high |
| hold_empty | output | 1 | Holding stage empty |
| tx_empty | output | 1 | Holding stage and shifter both empty |
| irq | output | 1 | Holding-empty interrupt request |

## Verification
The framer is swept through all 32 line settings, each with four byte patterns. All-zero and all-one bytes expose bit-count and stop-bit errors, and the alternating and mixed bytes expose bit order and parity sense. The frame length is measured with a baud strobe at one third of the clock rate, which separates counting ticks from counting cycles. A burst of three writes in single-register mode and a burst of nineteen writes in queue mode tell discarded writes apart from accepted ones, check ordering, and check that back-to-back frames have no gap. The status and interrupt flags are sampled at the exact cycles where they must change.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  // start + 8 data + parity + 2 stop
  localparam int FRAME_MAX = 12;
  localparam int TAIL_W    = FRAME_MAX - 1;

  typedef struct packed {
    logic [1:0] len;
    logic       par_en;
    logic       par_even;
    logic       stop2;
  } line_cfg_t;

  // bits that follow the start bit, first one at index 0
  typedef struct packed {
    logic [TAIL_W-1:0] tail;
    logic [3:0]        nbits;
  } frame_t;

  function automatic frame_t pack_frame(input logic [7:0] d, input line_cfg_t c);
    frame_t     f;
    logic [3:0] n;
    logic       p;
    int         w;
    w      = 5 + int'(c.len);
    f.tail = '1;
    n      = 4'd0;
    p      = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i < w) begin
        f.tail[n] = d[i];
        p         = p ^ d[i];
        n         = n + 4'd1;
      end
    end
    if (c.par_en) begin
      f.tail[n] = c.par_even ? p : ~p;
      n         = n + 4'd1;
    end
    f.tail[n] = 1'b1;
    n         = n + 4'd1;
    if (c.stop2) begin
      f.tail[n] = 1'b1;
      n         = n + 4'd1;
    end
    f.nbits = n;
    return f;
  endfunction

endpackage

// File: rtl/tx_hold_fifo.sv
module tx_hold_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_en,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          pop,
  output logic [W-1:0]  rd_data,
  output logic [AW:0]   level,
  output logic [AW:0]   level_nxt
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt, cap;
  logic          wr_ok;

  // single-register mode is the same queue capped at one entry
  assign cap   = fifo_en ? (AW+1)'(DEPTH) : (AW+1)'(1);
  assign wr_ok = wr_en && ((cnt < cap) || pop);

  // no reset on the array so it maps onto on-chip RAM
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wr_data;
  end

  assign rd_data   = mem[rp];
  assign level     = cnt;
  assign level_nxt = cnt + (AW+1)'(wr_ok) - (AW+1)'(pop);

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_ok) wp <= wp + AW'(1);
      if (pop)   rp <= rp + AW'(1);
      cnt <= level_nxt;
    end
  end

endmodule

// File: rtl/tx_serializer.sv
module tx_serializer
  import uart_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      baud_tick,
  input  line_cfg_t cfg,
  input  logic      hold_avail,
  input  logic [7:0] hold_data,
  output logic      pop,
  output logic      txd,
  output logic      busy_nxt
);

  logic              busy_q, txd_q;
  logic [3:0]        sub, left;
  logic [TAIL_W-1:0] sh;
  logic              bit_end, last;
  frame_t            f;

  assign f       = pack_frame(hold_data, cfg);
  assign bit_end = busy_q && baud_tick && (sub == 4'd15);
  assign last    = bit_end && (left == 4'd0);
  assign pop     = hold_avail && (!busy_q || last);
  assign busy_nxt = pop || (busy_q && !last);
  assign txd     = txd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      txd_q  <= 1'b1;
      sub    <= 4'd0;
      left   <= 4'd0;
      sh     <= '1;
    end else if (pop) begin
      busy_q <= 1'b1;
      txd_q  <= 1'b0;
      sub    <= 4'd0;
      left   <= f.nbits;
      sh     <= f.tail;
    end else begin
      if (busy_q && baud_tick) sub <= sub + 4'd1;
      if (last) begin
        busy_q <= 1'b0;
        txd_q  <= 1'b1;
      end else if (bit_end) begin
        txd_q <= sh[0];
        sh    <= {1'b1, sh[TAIL_W-1:1]};
        left  <= left - 4'd1;
      end
    end
  end

endmodule

// File: rtl/uart_tx_path.sv
module uart_tx_path
  import uart_tx_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       fifo_en,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_even,
  input  logic       cfg_stop2,
  input  logic       hold_irq_en,
  input  logic       baud_tick,
  output logic       txd,
  output logic       hold_empty,
  output logic       tx_empty,
  output logic       irq
);

  line_cfg_t   cfg;
  logic [7:0]  hold_data;
  logic [AW:0] hold_level, hold_level_nxt;
  logic        pop, busy_nxt;
  logic        hold_empty_q, tx_empty_q, irq_q;

  assign cfg = '{len: cfg_len, par_en: cfg_par_en, par_even: cfg_par_even, stop2: cfg_stop2};

  tx_hold_fifo #(.DEPTH(DEPTH), .W(8)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .fifo_en   (fifo_en),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .pop       (pop),
    .rd_data   (hold_data),
    .level     (hold_level),
    .level_nxt (hold_level_nxt)
  );

  tx_serializer u_ser (
    .clk        (clk),
    .rst        (rst),
    .baud_tick  (baud_tick),
    .cfg        (cfg),
    .hold_avail (hold_level != '0),
    .hold_data  (hold_data),
    .pop        (pop),
    .txd        (txd),
    .busy_nxt   (busy_nxt)
  );

  // flags registered from next-state terms so they line up with the data path
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_empty_q <= 1'b1;
      tx_empty_q   <= 1'b1;
      irq_q        <= 1'b0;
    end else begin
      hold_empty_q <= (hold_level_nxt == '0);
      tx_empty_q   <= (hold_level_nxt == '0) && !busy_nxt;
      irq_q        <= hold_irq_en && (hold_level_nxt == '0);
    end
  end

  assign hold_empty = hold_empty_q;
  assign tx_empty   = tx_empty_q;
  assign irq        = irq_q;

endmodule

// File: rtl/uart_tx_path_chk.sv
module uart_tx_path_chk #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic        clk,
  input logic        rst,
  input logic        wr_en,
  input logic        hold_irq_en,
  input logic        txd,
  input logic        hold_empty,
  input logic        tx_empty,
  input logic        irq,
  input logic [AW:0] level
);

  // R8: a drained transmitter implies a drained holding stage
  a_r8_empty_implies_hold: assert property (@(posedge clk) disable iff (rst)
    tx_empty |-> hold_empty);

  // R3: the line rests high whenever nothing is in flight
  a_r3_idle_line_high: assert property (@(posedge clk) disable iff (rst)
    tx_empty |-> txd);

  // R9: request tracks the flag gated by the enable seen one cycle earlier
  a_r9_irq_follows_flag: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq == (hold_empty && $past(hold_irq_en))));

  // R7: the queue never holds more than its depth
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    level <= (AW+1)'(DEPTH));

  // R4: a write into an empty holding stage clears the flag on the next cycle
  a_r4_write_clears_flag: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hold_empty) |=> !hold_empty);

endmodule

bind uart_tx_path uart_tx_path_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .hold_irq_en (hold_irq_en),
  .txd         (txd),
  .hold_empty  (hold_empty),
  .tx_empty    (tx_empty),
  .irq         (irq),
  .level       (hold_level)
);

// File: tb/sim_uart_tx_path.sv
module sim_uart_tx_path;
  localparam int DEPTH = 16;

  logic       clk = 1'b0, rst = 1'b1;
  logic       wr_en = 1'b0, fifo_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] cfg_len = 2'd3;
  logic       cfg_par_en = 1'b0, cfg_par_even = 1'b0, cfg_stop2 = 1'b0;
  logic       hold_irq_en = 1'b0, baud_tick = 1'b0;
  logic       txd, hold_empty, tx_empty, irq;

  int vec = 0, bad = 0, div = 1, cyc = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_tx_path #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .fifo_en(fifo_en),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_stop2(cfg_stop2), .hold_irq_en(hold_irq_en), .baud_tick(baud_tick),
    .txd(txd), .hold_empty(hold_empty), .tx_empty(tx_empty), .irq(irq)
  );

  // baud strobe: one tick every div cycles, changed away from the edge
  initial begin
    int c = 0;
    forever begin
      @(posedge clk); #2;
      c = (c + 1 >= div) ? 0 : c + 1;
      baud_tick = (c == 0);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vec++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    int k = 0;
    while (k < n) begin
      @(negedge clk);
      if (baud_tick) k++;
    end
  endtask

  // bench-side receiver; returns at the centre of the last stop bit
  task automatic rx(input int tmo, input int w, input bit pe, input bit s2,
                    output bit found, output int data, output int par, output bit frame_ok);
    found = 1'b0; data = 0; par = 0; frame_ok = 1'b1;
    for (int i = 0; i < tmo && !found; i++) begin
      @(negedge clk);
      if (txd == 1'b0) found = 1'b1;
    end
    if (!found) return;
    wait_ticks(8);
    if (txd !== 1'b0) frame_ok = 1'b0;
    for (int i = 0; i < w; i++) begin
      wait_ticks(16);
      data = data | (int'(txd) << i);
    end
    if (pe) begin
      wait_ticks(16);
      par = int'(txd);
    end
    wait_ticks(16);
    if (txd !== 1'b1) frame_ok = 1'b0;
    if (s2) begin
      wait_ticks(16);
      if (txd !== 1'b1) frame_ok = 1'b0;
    end
  endtask

  task automatic write_byte(input logic [7:0] b);
    @(negedge clk);
    wr_en = 1'b1; wr_data = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && !tx_empty; i++) @(negedge clk);
  endtask

  function automatic int exp_par(input int d, input int w, input bit even);
    int p = 0;
    for (int i = 0; i < w; i++) p = p ^ ((d >> i) & 1);
    return even ? p : (p ^ 1);
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
  endtask

  // watchdog
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 150000 && !done) begin
        done = 1'b1;
        vec++; bad++;
        $display("FAIL watchdog all-requirements actual=%0d expected<150000", cyc);
        summary();
        $finish;
      end
    end
  end

  initial begin
    bit found, fok;
    int data, par, t0, t1;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R3: reset state
    check(txd == 1'b1,        "R3 txd after reset",        int'(txd), 1);
    check(hold_empty == 1'b1, "R3 hold_empty after reset", int'(hold_empty), 1);
    check(tx_empty == 1'b1,   "R3 tx_empty after reset",   int'(tx_empty), 1);
    check(irq == 1'b0,        "R3 irq after reset",        int'(irq), 0);

    // R9: enable raises irq one cycle later
    hold_irq_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(irq == 1'b1, "R9 irq with enable", int'(irq), 1);

    // R4: flag timing around a single write, shifter idle
    fork
      write_byte(8'h3C);
      rx(50, 8, 1'b0, 1'b0, found, data, par, fok);
    join_any
    check(hold_empty == 1'b0, "R4 hold_empty after write", int'(hold_empty), 0);
    check(irq == 1'b0,        "R9 irq drops with flag",    int'(irq), 0);
    check(tx_empty == 1'b0,   "R8 tx_empty after write",   int'(tx_empty), 0);
    @(negedge clk);
    check(hold_empty == 1'b1, "R4 hold_empty after load",  int'(hold_empty), 1);
    check(irq == 1'b1,        "R9 irq returns with flag",  int'(irq), 1);
    check(tx_empty == 1'b0,   "R8 tx_empty while shifting", int'(tx_empty), 0);
    hold_irq_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(irq == 1'b0, "R9 irq with enable cleared", int'(irq), 0);
    wait fork;
    check(found && fok && data == 8'h3C, "R1 single frame 8N1", data, 8'h3C);
    wait_idle();
    check(tx_empty == 1'b1, "R8 tx_empty after last stop", int'(tx_empty), 1);

    // R1: sweep all line settings with four byte patterns
    for (int cf = 0; cf < 32; cf++) begin
      cfg_len      = cf[1:0];
      cfg_par_en   = cf[2];
      cfg_par_even = cf[3];
      cfg_stop2    = cf[4];
      for (int k = 0; k < 4; k++) begin
        int w, d, m, ok;
        w = 5 + cf[1:0];
        m = (1 << w) - 1;
        d = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (k == 2) ? 8'h55 : (8'hA6 ^ cf);
        fork
          write_byte(8'(d));
          rx(50, w, cf[2], cf[4], found, data, par, fok);
        join
        ok = found && fok && (data == (d & m)) &&
             (!cf[2] || par == exp_par(d & m, w, cf[3]));
        check(ok == 1, $sformatf("R1 frame cfg=%0d byte=%0h", cf, d), data, d & m);
        wait_idle();
      end
    end

    // R2: frame duration with a slower strobe, 8N1 = 10 bits
    cfg_len = 2'd3; cfg_par_en = 1'b0; cfg_par_even = 1'b0; cfg_stop2 = 1'b0;
    div = 3;
    repeat (6) @(negedge clk);
    write_byte(8'hC9);
    t0 = cyc;
    for (int i = 0; i < 50 && txd; i++) @(negedge clk);
    t0 = cyc;
    for (int i = 0; i < 2000 && !tx_empty; i++) @(negedge clk);
    t1 = cyc - t0;
    check(t1 >= 160*3 - 2 && t1 <= 160*3, "R2 frame length in ticks", t1, 480);
    fork
      write_byte(8'h96);
      rx(50, 8, 1'b0, 1'b0, found, data, par, fok);
    join
    check(found && fok && data == 8'h96, "R2 frame at slow strobe", data, 8'h96);
    wait_idle();
    div = 1;
    repeat (4) @(negedge clk);

    // R5 / R10: single register, third write discarded
    fifo_en = 1'b0;
    fork
      begin
        write_byte(8'hA1);
        write_byte(8'hB2);
        check(hold_empty == 1'b0, "R5 register occupied", int'(hold_empty), 0);
        write_byte(8'hC3);
      end
      begin
        rx(50, 8, 1'b0, 1'b0, found, data, par, fok);
        check(found && fok && data == 8'hA1, "R5 first byte", data, 8'hA1);
        rx(12, 8, 1'b0, 1'b0, found, data, par, fok);
        check(found && fok && data == 8'hB2, "R10 second byte back to back", data, 8'hB2);
        rx(400, 8, 1'b0, 1'b0, found, data, par, fok);
        check(!found, "R5 write while full discarded", int'(found), 0);
      end
    join
    check(tx_empty == 1'b1 && txd == 1'b1, "R8 idle after burst", int'(tx_empty), 1);

    // R6 / R7 / R10: queue mode, 19 writes, 17 accepted
    fifo_en = 1'b1;
    repeat (2) @(negedge clk);
    fork
      begin
        @(negedge clk);
        wr_en = 1'b1;
        for (int i = 0; i < 19; i++) begin
          wr_data = 8'(i*13 + 7);
          @(negedge clk);
        end
        wr_en = 1'b0;
      end
      begin
        for (int k = 0; k < 17; k++) begin
          rx((k == 0) ? 50 : 12, 8, 1'b0, 1'b0, found, data, par, fok);
          check(found && fok && data == ((k*13 + 7) & 255),
                $sformatf("R6 queued byte %0d in order (R10 no gap)", k), data, (k*13 + 7) & 255);
          if (k == 15)
            check(hold_empty == 1'b0, "R6 flag low while byte waits", int'(hold_empty), 0);
          if (k == 16) begin
            check(hold_empty == 1'b1, "R6 flag high once queue empty", int'(hold_empty), 1);
            check(tx_empty == 1'b0,   "R8 busy shifter keeps tx_empty low", int'(tx_empty), 0);
          end
        end
        rx(400, 8, 1'b0, 1'b0, found, data, par, fok);
        check(!found, "R7 writes into full queue discarded", int'(found), 0);
      end
    join
    check(tx_empty == 1'b1, "R8 drained after queue", int'(tx_empty), 1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule